// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block gathers interrupt requests from several groups of peripheral sources and presents them to a processor on one request line. Every group owns a sticky status register and a mask register. The status bits that the group mask enables are ORed together to form one bit of a first-level status word. A few sources skip the group stage and set their own first-level bit directly. A first-level mask register gates the processor request. All mask registers come out of reset at zero, and a zero bit masks its request. Nothing reaches the processor until software enables it.

A small word-addressed register port reads and writes the masks and the status registers. Status bits are cleared by writing a one to them. A suspend input changes the output stage. While suspend is high, the normal request is held low. A separate wake line then asserts for the first-level sources chosen in a wake-enable register.

The address map uses word addresses. Address 0 is first-level status. Address 1 is the first-level mask. Address 2 is wake-enable. Group g has its status at address 4+2g and its mask at address 5+2g. First-level bit g (for g below NUM_GROUPS) is the merged request of group g. First-level bit NUM_GROUPS+d is direct source d.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all mask registers and the wake-enable register read zero, and cpu_irq and wake_irq are low. A pending status bit does not raise cpu_irq while its masks are zero.
- R2: A high bit of grp_req (bit g*GROUP_W+b is group g, bit b) sets that group status bit at the clock edge where it is sampled. The bit then stays set until a write to address 4+2g with a one in bit b clears it. If a set and a clear reach the same bit in the same cycle, the set wins.
- R3: First-level status bit g, read at address 0, is one exactly when group g has at least one status bit whose group mask bit (address 5+2g) is one.
- R4: dir_req bit d sets first-level status bit NUM_GROUPS+d. That bit is sticky until a write to address 0 with a one in that position clears it. Writing ones to the group-derived bits of address 0 has no effect on them.
- R5: When suspend is low, cpu_irq is a register. It goes high one clock after some first-level status bit is set whose first-level mask bit (address 1) is one, and it goes low one clock after no such bit remains.
- R6: When suspend is high, cpu_irq is low. wake_irq goes high one clock after some first-level status bit is set whose wake-enable bit (address 2) is one, whatever the first-level mask holds. When suspend is low, wake_irq is low.
- R7: rdata is registered. It shows the register at the address sampled on the previous clock edge. Unmapped addresses read zero, and writes to them change no register.
- R8: The mask and wake-enable registers read back the value last written to them, cut to their width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_req | input | NUM_GROUPS*GROUP_W | Group source requests, group g in bits g*GROUP_W upward |
| dir_req | input | NUM_DIRECT | Requests from sources wired straight to first-level status |
| suspend | input | 1 | Suspend mode select |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| cpu_irq | output | 1 | Registered interrupt request to the processor |
| wake_irq | output | 1 | Registered general interrupt-source signal used in suspend |

## Verification
The bench checks the latency of cpu_irq in both directions. If the output were not registered, the request would show up in the same cycle. If the design read the status after the clear instead of before it, the request would stay up one cycle too short. The bench also clears a bit in the same cycle as a new event. A design that gave the clear priority would lose that event. It writes ones to the group-derived bits of address 0, writes to holes in the map, and clears the wrong bit of a group. A design with a loose decoder or a bad clear mask would change registers it should leave alone. Under suspend, the bench fires a source that is masked at first level but wake-enabled, and a source that is the other way round. A design that shared one mask across both paths would mix up cpu_irq and wake_irq.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADR_L1_STAT  = 0;
  localparam int unsigned ADR_L1_MASK  = 1;
  localparam int unsigned ADR_WAKE_EN  = 2;
  localparam int unsigned ADR_GRP_BASE = 4;

  function automatic int unsigned grp_stat_adr(input int unsigned g);
    return ADR_GRP_BASE + 2 * g;
  endfunction

  function automatic int unsigned grp_mask_adr(input int unsigned g);
    return ADR_GRP_BASE + 2 * g + 1;
  endfunction
endpackage

// File: rtl/irq_group_bank.sv
module irq_group_bank #(
  parameter int unsigned GROUP_W = 8,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GROUP_W-1:0] req,
  input  logic               stat_wr,
  input  logic               mask_wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [GROUP_W-1:0] stat,
  output logic [GROUP_W-1:0] mask,
  output logic               merged
);
  logic [GROUP_W-1:0] clr;

  // write-one-to-clear; a new request in the same cycle takes priority
  assign clr = stat_wr ? wdata[GROUP_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= (stat & ~clr) | req;
      if (mask_wr) mask <= wdata[GROUP_W-1:0];
    end
  end

  assign merged = |(stat & mask);
endmodule

// File: rtl/irq_direct_bank.sv
module irq_direct_bank #(
  parameter int unsigned NUM_DIRECT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_DIRECT-1:0] req,
  input  logic                  clr_wr,
  input  logic [NUM_DIRECT-1:0] clr_bits,
  output logic [NUM_DIRECT-1:0] stat
);
  logic [NUM_DIRECT-1:0] clr;

  assign clr = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr) | req;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned L1_W   = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [L1_W-1:0]   l1_stat,
  input  logic              mask_wr,
  input  logic              wake_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              suspend,
  output logic [L1_W-1:0]   l1_mask,
  output logic [L1_W-1:0]   wake_en,
  output logic              cpu_irq,
  output logic              wake_irq
);
  logic run_hit;
  logic wake_hit;

  assign run_hit  = |(l1_stat & l1_mask);
  assign wake_hit = |(l1_stat & wake_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      l1_mask  <= '0;
      wake_en  <= '0;
      cpu_irq  <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      if (mask_wr) l1_mask <= wdata[L1_W-1:0];
      if (wake_wr) wake_en <= wdata[L1_W-1:0];
      cpu_irq  <= run_hit & ~suspend;
      wake_irq <= wake_hit & suspend;
    end
  end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned L1_W       = 5,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [L1_W-1:0]               l1_stat,
  input  logic [L1_W-1:0]               l1_mask,
  input  logic [L1_W-1:0]               wake_en,
  input  logic [NUM_GROUPS*GROUP_W-1:0] gstat,
  input  logic [NUM_GROUPS*GROUP_W-1:0] gmask,
  output logic                          l1stat_wr,
  output logic                          l1mask_wr,
  output logic                          wake_wr,
  output logic [NUM_GROUPS-1:0]         gstat_wr,
  output logic [NUM_GROUPS-1:0]         gmask_wr,
  output logic [DATA_W-1:0]             rdata
);
  logic                  hit_l1stat, hit_l1mask, hit_wake;
  logic [NUM_GROUPS-1:0] hit_gstat, hit_gmask;
  logic [DATA_W-1:0]     rd_mux;

  assign hit_l1stat = (addr == ADDR_W'(ADR_L1_STAT));
  assign hit_l1mask = (addr == ADDR_W'(ADR_L1_MASK));
  assign hit_wake   = (addr == ADDR_W'(ADR_WAKE_EN));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign hit_gstat[g] = (addr == ADDR_W'(grp_stat_adr(g)));
    assign hit_gmask[g] = (addr == ADDR_W'(grp_mask_adr(g)));
  end

  assign l1stat_wr = wr_en & hit_l1stat;
  assign l1mask_wr = wr_en & hit_l1mask;
  assign wake_wr   = wr_en & hit_wake;
  assign gstat_wr  = {NUM_GROUPS{wr_en}} & hit_gstat;
  assign gmask_wr  = {NUM_GROUPS{wr_en}} & hit_gmask;

  always_comb begin
    rd_mux = '0;
    if (hit_l1stat) rd_mux[L1_W-1:0] = l1_stat;
    if (hit_l1mask) rd_mux[L1_W-1:0] = l1_mask;
    if (hit_wake)   rd_mux[L1_W-1:0] = wake_en;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (hit_gstat[g]) rd_mux[GROUP_W-1:0] = gstat[g*GROUP_W +: GROUP_W];
      if (hit_gmask[g]) rd_mux[GROUP_W-1:0] = gmask[g*GROUP_W +: GROUP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned NUM_DIRECT = 2,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_GROUPS*GROUP_W-1:0] grp_req,
  input  logic [NUM_DIRECT-1:0]         dir_req,
  input  logic                          suspend,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic                          cpu_irq,
  output logic                          wake_irq
);
  localparam int unsigned L1_W  = NUM_GROUPS + NUM_DIRECT;
  localparam int unsigned GTOT  = NUM_GROUPS * GROUP_W;

  logic [GTOT-1:0]       gstat_all, gmask_all;
  logic [NUM_GROUPS-1:0] grp_merged, gstat_wr, gmask_wr;
  logic [NUM_DIRECT-1:0] dir_stat;
  logic [L1_W-1:0]       l1_stat, l1_mask, wake_en;
  logic                  l1stat_wr, l1mask_wr, wake_wr;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irq_group_bank #(.GROUP_W(GROUP_W), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .req     (grp_req[g*GROUP_W +: GROUP_W]),
      .stat_wr (gstat_wr[g]),
      .mask_wr (gmask_wr[g]),
      .wdata   (wdata),
      .stat    (gstat_all[g*GROUP_W +: GROUP_W]),
      .mask    (gmask_all[g*GROUP_W +: GROUP_W]),
      .merged  (grp_merged[g])
    );
  end

  irq_direct_bank #(.NUM_DIRECT(NUM_DIRECT)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .req      (dir_req),
    .clr_wr   (l1stat_wr),
    .clr_bits (wdata[L1_W-1:NUM_GROUPS]),
    .stat     (dir_stat)
  );

  assign l1_stat = {dir_stat, grp_merged};

  irq_out_stage #(.L1_W(L1_W), .DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .l1_stat  (l1_stat),
    .mask_wr  (l1mask_wr),
    .wake_wr  (wake_wr),
    .wdata    (wdata),
    .suspend  (suspend),
    .l1_mask  (l1_mask),
    .wake_en  (wake_en),
    .cpu_irq  (cpu_irq),
    .wake_irq (wake_irq)
  );

  irq_reg_decode #(
    .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .L1_W(L1_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .l1_stat   (l1_stat),
    .l1_mask   (l1_mask),
    .wake_en   (wake_en),
    .gstat     (gstat_all),
    .gmask     (gmask_all),
    .l1stat_wr (l1stat_wr),
    .l1mask_wr (l1mask_wr),
    .wake_wr   (wake_wr),
    .gstat_wr  (gstat_wr),
    .gmask_wr  (gmask_wr),
    .rdata     (rdata)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned GTOT = 24,
  parameter int unsigned L1_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            suspend,
  input logic            wr_en,
  input logic [GTOT-1:0] grp_req,
  input logic [GTOT-1:0] gstat,
  input logic [GTOT-1:0] gmask,
  input logic [L1_W-1:0] l1_stat,
  input logic [L1_W-1:0] l1_mask,
  input logic [L1_W-1:0] wake_en,
  input logic            cpu_irq,
  input logic            wake_irq
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      assert_mask_reset_R1: assert (l1_mask == '0 && gmask == '0 && wake_en == '0 && !cpu_irq && !wake_irq)
        else $error("masks or outputs not cleared by reset");
    end
  end

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (rst)
    |grp_req |=> ((gstat & $past(grp_req)) == $past(grp_req)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((gstat & $past(gstat)) == $past(gstat)));

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> $past(|(l1_stat & l1_mask)));

  assert_suspend_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    suspend |=> !cpu_irq);

  assert_wake_only_suspend_R6: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> $past(suspend));
endmodule

bind irq_aggregator irq_aggregator_chk #(.GTOT(GTOT), .L1_W(L1_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .suspend  (suspend),
  .wr_en    (wr_en),
  .grp_req  (grp_req),
  .gstat    (gstat_all),
  .gmask    (gmask_all),
  .l1_stat  (l1_stat),
  .l1_mask  (l1_mask),
  .wake_en  (wake_en),
  .cpu_irq  (cpu_irq),
  .wake_irq (wake_irq)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int G = 3, GW = 8, D = 2, AW = 5, DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [G*GW-1:0] grp_req;
  logic [D-1:0]  dir_req;
  logic          suspend;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          cpu_irq;
  logic          wake_irq;

  int checks = 0;
  int errors = 0;

  irq_aggregator #(.NUM_GROUPS(G), .GROUP_W(GW), .NUM_DIRECT(D), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .grp_req(grp_req), .dir_req(dir_req), .suspend(suspend),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .cpu_irq(cpu_irq), .wake_irq(wake_irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic pulse_grp(input int idx);
    @(negedge clk);
    grp_req[idx] = 1'b1;
    @(negedge clk);
    grp_req[idx] = 1'b0;
  endtask

  task automatic pulse_dir(input int d);
    @(negedge clk);
    dir_req[d] = 1'b1;
    @(negedge clk);
    dir_req[d] = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    chk("R1 cpu_irq after reset", DW'(cpu_irq), '0);
    chk("R1 wake_irq after reset", DW'(wake_irq), '0);
    rd(1, v); chk("R1 l1 mask reset", v, '0);
    rd(5, v); chk("R1 group0 mask reset", v, '0);
    rd(2, v); chk("R1 wake enable reset", v, '0);
  endtask

  task automatic t_group;
    logic [DW-1:0] v;
    pulse_grp(1*GW + 3);
    rd(6, v); chk("R2 group1 status set", v, 16'h0008);
    rd(0, v); chk("R3 masked group gives no l1 bit", v, '0);
    chk("R1 no irq while masked", DW'(cpu_irq), '0);
    wr(7, 16'h0008);
    rd(7, v); chk("R8 group1 mask readback", v, 16'h0008);
    rd(0, v); chk("R3 enabled group sets l1 bit1", v, 16'h0002);
    repeat (4) @(negedge clk);
    rd(6, v); chk("R2 status sticky", v, 16'h0008);
    wr(6, 16'h0001);
    rd(6, v); chk("R2 clearing other bit keeps status", v, 16'h0008);
    wr(6, 16'h0008);
    rd(6, v); chk("R2 w1c clears status", v, '0);
    rd(0, v); chk("R3 l1 bit follows cleared group", v, '0);
  endtask

  task automatic t_cpu;
    logic [DW-1:0] v;
    wr(1, 16'h0002);
    rd(1, v); chk("R8 l1 mask readback", v, 16'h0002);
    pulse_grp(1*GW + 3);
    chk("R5 irq waits one clock", DW'(cpu_irq), '0);
    @(negedge clk);
    chk("R5 irq asserted", DW'(cpu_irq), 1);
    wr(6, 16'h0008);
    chk("R5 irq still high in clear cycle", DW'(cpu_irq), 1);
    @(negedge clk);
    chk("R5 irq drops one clock after clear", DW'(cpu_irq), '0);
  endtask

  task automatic t_direct;
    logic [DW-1:0] v;
    pulse_grp(1*GW + 3);
    pulse_dir(1);
    rd(0, v); chk("R4 direct and group bits", v, 16'h0012);
    wr(0, 16'h001F);
    rd(0, v); chk("R4 w1c clears direct only", v, 16'h0002);
    wr(6, 16'h0008);
    rd(0, v); chk("R4 all clear", v, '0);
  endtask

  task automatic t_suspend;
    logic [DW-1:0] v;
    wr(2, 16'h0008);
    rd(2, v); chk("R8 wake enable readback", v, 16'h0008);
    @(negedge clk); suspend = 1'b1;
    pulse_grp(1*GW + 3);
    @(negedge clk);
    chk("R6 cpu_irq held low in suspend", DW'(cpu_irq), '0);
    chk("R6 no wake for non-enabled source", DW'(wake_irq), '0);
    pulse_dir(0);
    chk("R6 wake waits one clock", DW'(wake_irq), '0);
    @(negedge clk);
    chk("R6 wake from enabled source", DW'(wake_irq), 1);
    chk("R6 cpu_irq still low", DW'(cpu_irq), '0);
    suspend = 1'b0;
    @(negedge clk);
    chk("R5 irq back after suspend", DW'(cpu_irq), 1);
    chk("R6 wake low outside suspend", DW'(wake_irq), '0);
    wr(0, 16'h0018);
    wr(6, 16'h0008);
    @(negedge clk);
    @(negedge clk);
    chk("R5 irq low after clearing", DW'(cpu_irq), '0);
  endtask

  task automatic t_set_wins;
    logic [DW-1:0] v;
    @(negedge clk);
    grp_req[0] = 1'b1;
    wr_en = 1'b1; addr = AW'(4); wdata = 16'h0001;
    @(negedge clk);
    grp_req[0] = 1'b0; wr_en = 1'b0; wdata = '0;
    rd(4, v); chk("R2 set beats clear", v, 16'h0001);
    wr(4, 16'h0001);
    rd(4, v); chk("R2 cleared after", v, '0);
  endtask

  task automatic t_unmapped;
    logic [DW-1:0] v;
    wr(3, 16'hFFFF);
    wr(31, 16'hFFFF);
    wr(10, 16'hFFFF);
    rd(3, v);  chk("R7 unmapped 3 reads zero", v, '0);
    rd(31, v); chk("R7 unmapped 31 reads zero", v, '0);
    rd(10, v); chk("R7 unmapped 10 reads zero", v, '0);
    rd(1, v);  chk("R7 l1 mask untouched", v, 16'h0002);
    rd(2, v);  chk("R7 wake enable untouched", v, 16'h0008);
    rd(9, v);  chk("R7 group2 mask untouched", v, '0);
    chk("R7 no irq from unmapped write", DW'(cpu_irq), '0);
  endtask

  initial begin
    rst = 1'b1; grp_req = '0; dir_req = '0; suspend = 1'b0;
    wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_group;
    t_cpu;
    t_direct;
    t_suspend;
    t_set_wins;
    t_unmapped;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule